// File: doc/BRIEF.md
# Armed SPI Master with Bus Handshake

This block is a single-channel SPI master, seen by software as a small set of bus registers. It exchanges one word per transfer, full duplex. Software loads the outgoing word and then sets an arm bit. The master lowers chip select and clocks the word out most significant bit first, shifting the reply in from MISO at the same time. It then raises a finished flag. Software reads the reply and clears arm, which returns the master to idle and raises the ready flag.

The status word holds two flags. Bit 0 is ready (idle and unarmed) and bit 1 is finished (armed and done). The status can be read in two ways. A plain read returns it at once. A blocking read holds back the bus acknowledge until at least one flag is set, so a polling loop becomes one bus access. Clearing arm part way through a transfer aborts it. Word width, clock phase and the SCK divider are set at build time. SCK idles low. The bus side takes an active-high reset, which is inverted to give the active-low reset of the shift engine.

Top module: `spi_arm_master`

## Requirements
- R1: After reset the status reads 2'b01, spi_cs_n is high, spi_sck is low, and the arm, tx and rx registers read zero. spi_cs_n falls only after the arm bit has been set.
- R2: The status register at byte offset 0x00 returns ready in bit 0 (arm clear and master idle) and finished in bit 1 (arm set and transfer complete). It reads 2'b00 while a transfer is under way, and the two bits are never set together.
- R3: A read at offset 0x10 returns the same two bits, but it is not acknowledged while both bits are zero. It is acknowledged one cycle after issue when a bit is already set.
- R4: Each transfer drives the tx word onto spi_mosi MSB first. It collects the spi_miso bits MSB first into the rx word, which is readable at offset 0x0C (upper bits zero).
- R5: With CPHA = 0, MOSI changes only while SCK is low and MISO is sampled on rising edges. With CPHA = 1, MOSI changes only on rising edges and MISO is sampled on falling edges.
- R6: SCK has a half-period of HALF_DIV clocks. The first rising edge comes HALF_DIV clocks after spi_cs_n falls. A transfer has exactly WORD_W rising edges, and SCK is low whenever spi_cs_n is high.
- R7: spi_cs_n stays low for the whole transfer. It rises HALF_DIV clocks after the last SCK falling edge and is high by the cycle in which finished rises.
- R8: Clearing arm during a transfer releases spi_cs_n, forces SCK low and raises ready within two clocks of the write. The rx word keeps its previous value, and the next transfer runs normally.
- R9: The rx word keeps its value once a transfer completes. It is unchanged by clearing arm and by writes to the tx register, until the next transfer completes.
- R10: The arm bit is bit 0 of offset 0x04, and the tx word sits at offset 0x08. Both read back what was written, the tx word masked to WORD_W bits. Writes to 0x00, 0x0C and 0x10 are acknowledged and have no effect. Every other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high asynchronous reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe; held with the request until acknowledged |
| bus_we | input | 1 | Write enable |
| bus_adr | input | ADDR_W | Byte offset of the register |
| bus_wdat | input | DATA_W | Write data |
| bus_rdat | output | DATA_W | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The checker watches several invariants on every clock:
- the two status flags are never set together;
- a blocking read is never acknowledged while the status is zero;
- SCK is low whenever chip select is released, and chip select falls only after arm is set;
- chip select is high when finished rises, and it releases one cycle after arm drops;
- the rx word does not move while arm is clear.

Other properties can only be shown by the directed scenarios, which drive a bench slave model:
- bit order and the data exchanged in both directions;
- the edge used for each phase setting;
- the half-period and tail timing;
- the rise count per word;
- the stall length of the blocking read;
- the register decode.

// File: rtl/spi_arm_pkg.sv
package spi_arm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_TAIL,
      ST_DONE
   } spi_arm_state_t;

   typedef struct packed {
      logic finished;
      logic ready;
   } spi_arm_status_t;

   localparam logic [4:0] OFS_STATUS = 5'h00;
   localparam logic [4:0] OFS_ARM    = 5'h04;
   localparam logic [4:0] OFS_TXD    = 5'h08;
   localparam logic [4:0] OFS_RXD    = 5'h0C;
   localparam logic [4:0] OFS_WAIT   = 5'h10;

endpackage

// File: rtl/spi_arm_halfdiv.sv
module spi_arm_halfdiv #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_arm_core.sv
module spi_arm_core
   import spi_arm_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int CPHA     = 0,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              cs_n,
   output spi_arm_status_t   status,
   output logic [WORD_W-1:0] rx_word
);
   localparam int EDGES = 2 * WORD_W;
   localparam int EW    = $clog2(EDGES);
   localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

   spi_arm_state_t    st;
   logic [EW-1:0]     edge_n;
   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_sh;
   logic [WORD_W-1:0] rx_next;
   logic              tick;
   logic              div_run;

   assign div_run = (st == ST_SHIFT) || (st == ST_TAIL);
   assign rx_next = {rx_sh[WORD_W-2:0], miso};
   assign mosi    = tx_sh[WORD_W-1];

   assign status.ready    = (st == ST_IDLE) && !arm;
   assign status.finished = (st == ST_DONE) && arm;

   spi_arm_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (div_run),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         sck     <= 1'b0;
         cs_n    <= 1'b1;
         edge_n  <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         rx_word <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (arm) begin
                  st     <= ST_SHIFT;
                  cs_n   <= 1'b0;
                  tx_sh  <= tx_word;
                  edge_n <= '0;
               end
            end
            ST_SHIFT: begin
               if (!arm) begin
                  st   <= ST_IDLE;
                  cs_n <= 1'b1;
                  sck  <= 1'b0;
               end else if (tick) begin
                  sck    <= ~sck;
                  edge_n <= edge_n + 1'b1;
                  if (!sck) begin
                     // rising edge
                     if (CPHA == 0)
                        rx_sh <= rx_next;
                     else if (edge_n != '0)
                        tx_sh <= tx_sh << 1;
                  end else begin
                     // falling edge
                     if (CPHA == 0)
                        tx_sh <= tx_sh << 1;
                     else
                        rx_sh <= rx_next;
                  end
                  if (edge_n == LAST_EDGE) begin
                     st      <= ST_TAIL;
                     rx_word <= (CPHA == 0) ? rx_sh : rx_next;
                  end
               end
            end
            ST_TAIL: begin
               if (!arm) begin
                  st   <= ST_IDLE;
                  cs_n <= 1'b1;
                  sck  <= 1'b0;
               end else if (tick) begin
                  st   <= ST_DONE;
                  cs_n <= 1'b1;
               end
            end
            default: begin
               if (!arm)
                  st <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/spi_arm_regs.sv
module spi_arm_regs
   import spi_arm_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_cyc,
   input  logic              bus_stb,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_adr,
   input  logic [DATA_W-1:0] bus_wdat,
   output logic [DATA_W-1:0] bus_rdat,
   output logic              bus_ack,
   output logic              arm,
   output logic [WORD_W-1:0] tx_word,
   input  spi_arm_status_t   status,
   input  logic [WORD_W-1:0] rx_word
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_ARM    = ADDR_W'(OFS_ARM);
   localparam logic [ADDR_W-1:0] A_TXD    = ADDR_W'(OFS_TXD);
   localparam logic [ADDR_W-1:0] A_RXD    = ADDR_W'(OFS_RXD);
   localparam logic [ADDR_W-1:0] A_WAIT   = ADDR_W'(OFS_WAIT);

   logic              req;
   logic              hold;
   logic [DATA_W-1:0] rx_ext;
   logic [DATA_W-1:0] tx_ext;
   logic [DATA_W-1:0] rd_mux;
   logic              unused_wdat;

   assign unused_wdat = ^bus_wdat;
   assign req  = bus_cyc && bus_stb && !bus_ack;
   assign hold = !bus_we && (bus_adr == A_WAIT) && (status == '0);

   generate
      if (WORD_W < DATA_W) begin : g_pad
         assign rx_ext = {{(DATA_W - WORD_W){1'b0}}, rx_word};
         assign tx_ext = {{(DATA_W - WORD_W){1'b0}}, tx_word};
      end else begin : g_full
         assign rx_ext = rx_word;
         assign tx_ext = tx_word;
      end
   endgenerate

   always_comb begin
      case (bus_adr)
         A_STATUS, A_WAIT: rd_mux = {{(DATA_W - 2){1'b0}}, status};
         A_ARM:            rd_mux = {{(DATA_W - 1){1'b0}}, arm};
         A_TXD:            rd_mux = tx_ext;
         A_RXD:            rd_mux = rx_ext;
         default:          rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         bus_ack  <= 1'b0;
         bus_rdat <= '0;
         arm      <= 1'b0;
         tx_word  <= '0;
      end else begin
         bus_ack <= 1'b0;
         if (req && !hold) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
               if (bus_adr == A_ARM)
                  arm <= bus_wdat[0];
               if (bus_adr == A_TXD)
                  tx_word <= bus_wdat[WORD_W-1:0];
            end else begin
               bus_rdat <= rd_mux;
            end
         end
      end
   end
endmodule

// File: rtl/spi_arm_master.sv
module spi_arm_master
   import spi_arm_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter int CPHA     = 0,
   parameter int HALF_DIV = 2,
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_cyc,
   input  logic              bus_stb,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_adr,
   input  logic [DATA_W-1:0] bus_wdat,
   output logic [DATA_W-1:0] bus_rdat,
   output logic              bus_ack,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);
   generate
      if (WORD_W < 8 || WORD_W > 32) begin : g_bad_word
         $error("spi_arm_master: WORD_W must lie in 8..32");
      end
      if (CPHA != 0 && CPHA != 1) begin : g_bad_phase
         $error("spi_arm_master: CPHA must be 0 or 1");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("spi_arm_master: HALF_DIV must be at least 1");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("spi_arm_master: ADDR_W must be at least 5");
      end
      if (DATA_W < WORD_W) begin : g_bad_data
         $error("spi_arm_master: DATA_W must cover WORD_W");
      end
   endgenerate

   logic              rst_n;
   logic              arm_q;
   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] rx_word;
   spi_arm_status_t   status;

   assign rst_n = ~rst;

   spi_arm_regs #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .bus_cyc  (bus_cyc),
      .bus_stb  (bus_stb),
      .bus_we   (bus_we),
      .bus_adr  (bus_adr),
      .bus_wdat (bus_wdat),
      .bus_rdat (bus_rdat),
      .bus_ack  (bus_ack),
      .arm      (arm_q),
      .tx_word  (tx_q),
      .status   (status),
      .rx_word  (rx_word)
   );

   spi_arm_core #(
      .WORD_W   (WORD_W),
      .CPHA     (CPHA),
      .HALF_DIV (HALF_DIV)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm_q),
      .tx_word (tx_q),
      .miso    (spi_miso),
      .sck     (spi_sck),
      .mosi    (spi_mosi),
      .cs_n    (spi_cs_n),
      .status  (status),
      .rx_word (rx_word)
   );
endmodule

// File: rtl/spi_arm_master_chk.sv
module spi_arm_master_chk
   import spi_arm_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_cyc,
   input logic              bus_stb,
   input logic              bus_we,
   input logic              bus_ack,
   input logic [ADDR_W-1:0] bus_adr,
   input logic              spi_sck,
   input logic              spi_cs_n,
   input logic              arm_q,
   input logic [1:0]        status,
   input logic [WORD_W-1:0] rx_word
);
   localparam logic [ADDR_W-1:0] A_WAIT = ADDR_W'(OFS_WAIT);

   // R2: ready and finished are mutually exclusive
   a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(status[0] && status[1]));

   // R3: a blocking read with zero status gets no acknowledge next cycle
   a_r3_wait_stalls: assert property (@(posedge clk) disable iff (rst)
      (bus_cyc && bus_stb && !bus_ack && !bus_we && bus_adr == A_WAIT && status == 2'b00)
      |=> !bus_ack);

   // R6: SCK is parked low while chip select is released
   a_r6_sck_parked: assert property (@(posedge clk) disable iff (rst)
      spi_cs_n |-> !spi_sck);

   // R7: chip select already high when finished rises
   a_r7_cs_before_done: assert property (@(posedge clk) disable iff (rst)
      $rose(status[1]) |-> spi_cs_n);

   // R8: disarming with chip select low releases it on the next cycle
   a_r8_abort_release: assert property (@(posedge clk) disable iff (rst)
      (!arm_q && !spi_cs_n) |=> spi_cs_n);

   // R9: the received word holds while arm is clear
   a_r9_rx_held: assert property (@(posedge clk) disable iff (rst)
      !arm_q |=> $stable(rx_word));

   // R1: chip select falls only after arm was set
   a_r1_select_needs_arm: assert property (@(posedge clk) disable iff (rst)
      $fell(spi_cs_n) |-> $past(arm_q));
endmodule

bind spi_arm_master spi_arm_master_chk #(
   .WORD_W (WORD_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bus_cyc  (bus_cyc),
   .bus_stb  (bus_stb),
   .bus_we   (bus_we),
   .bus_ack  (bus_ack),
   .bus_adr  (bus_adr),
   .spi_sck  (spi_sck),
   .spi_cs_n (spi_cs_n),
   .arm_q    (arm_q),
   .status   (status),
   .rx_word  (rx_word)
);

// File: tb/spi_arm_master_bench.sv
module spi_arm_slave_model #(
   parameter int W    = 8,
   parameter int CPHA = 0,
   parameter int HALF = 2
) (
   input  logic         clk,
   input  logic         sck,
   input  logic         cs_n,
   input  logic         mosi,
   input  logic [31:0]  slv_word,
   output logic         miso,
   output logic [31:0]  got,
   output int           last_rises,
   output int           bad_phase,
   output int           bad_gap
);
   logic [W-1:0] sh = '0;
   logic [W-1:0] rcv = '0;
   int rises = 0;
   int gap = 0;
   int lr = 0;
   int bp = 0;
   int bg = 0;
   logic cs_d = 1'b1;
   logic sck_d = 1'b0;
   logic mosi_d = 1'b0;

   assign miso = sh[W-1];
   assign got = 32'(rcv);
   assign last_rises = lr;
   assign bad_phase = bp;
   assign bad_gap = bg;

   always @(negedge clk) begin
      if (cs_d === 1'b1 && cs_n === 1'b0) begin
         sh = slv_word[W-1:0];
         rises = 0;
         gap = 1;
      end else if (cs_d === 1'b0 && cs_n === 1'b1) begin
         lr = rises;
         if (rises == W && gap != HALF) bg++;
         gap = 1;
      end else if (cs_n === 1'b0 && sck !== sck_d) begin
         if (gap != HALF) bg++;
         gap = 1;
         if (sck) begin
            rises++;
            if (CPHA == 0) rcv = {rcv[W-2:0], mosi};
            else if (rises > 1) sh = sh << 1;
         end else begin
            if (CPHA == 0) sh = sh << 1;
            else rcv = {rcv[W-2:0], mosi};
         end
      end else begin
         gap++;
      end
      if (cs_n === 1'b0 && cs_d === 1'b0 && mosi !== mosi_d &&
          ((CPHA == 0) ? (sck === 1'b1) : (sck === 1'b0)))
         bp++;
      cs_d = cs_n;
      sck_d = sck;
      mosi_d = mosi;
   end
endmodule

module spi_arm_master_bench;
   localparam int W0 = 8;
   localparam int H0 = 2;
   localparam int W1 = 12;
   localparam int H1 = 3;
   localparam logic [4:0] A_STATUS = 5'h00;
   localparam logic [4:0] A_ARM    = 5'h04;
   localparam logic [4:0] A_TXD    = 5'h08;
   localparam logic [4:0] A_RXD    = 5'h0C;
   localparam logic [4:0] A_WAIT   = 5'h10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic        sel = 1'b0;
   logic        b_cyc = 1'b0, b_stb = 1'b0, b_we = 1'b0;
   logic [4:0]  b_adr = '0;
   logic [31:0] b_wdat = '0;
   logic [31:0] rdat0, rdat1, rdat;
   logic        ack0, ack1, ack;
   logic        sck0, mosi0, miso0, cs0;
   logic        sck1, mosi1, miso1, cs1;
   logic [31:0] sw0 = '0, sw1 = '0;
   logic [31:0] got0, got1;
   int          lr0, lr1, bp0, bp1, bg0, bg1;

   assign rdat = sel ? rdat1 : rdat0;
   assign ack  = sel ? ack1 : ack0;

   spi_arm_master u_spi_arm_master (
      .clk(clk), .rst(rst),
      .bus_cyc(b_cyc && !sel), .bus_stb(b_stb && !sel), .bus_we(b_we),
      .bus_adr(b_adr), .bus_wdat(b_wdat), .bus_rdat(rdat0), .bus_ack(ack0),
      .spi_sck(sck0), .spi_mosi(mosi0), .spi_miso(miso0), .spi_cs_n(cs0)
   );

   spi_arm_master #(.WORD_W(W1), .CPHA(1), .HALF_DIV(H1)) u_spi_arm_master_ph1 (
      .clk(clk), .rst(rst),
      .bus_cyc(b_cyc && sel), .bus_stb(b_stb && sel), .bus_we(b_we),
      .bus_adr(b_adr), .bus_wdat(b_wdat), .bus_rdat(rdat1), .bus_ack(ack1),
      .spi_sck(sck1), .spi_mosi(mosi1), .spi_miso(miso1), .spi_cs_n(cs1)
   );

   spi_arm_slave_model #(.W(W0), .CPHA(0), .HALF(H0)) u_slv0 (
      .clk(clk), .sck(sck0), .cs_n(cs0), .mosi(mosi0), .slv_word(sw0),
      .miso(miso0), .got(got0), .last_rises(lr0), .bad_phase(bp0), .bad_gap(bg0)
   );

   spi_arm_slave_model #(.W(W1), .CPHA(1), .HALF(H1)) u_slv1 (
      .clk(clk), .sck(sck1), .cs_n(cs1), .mosi(mosi1), .slv_word(sw1),
      .miso(miso1), .got(got1), .last_rises(lr1), .bad_phase(bp1), .bad_gap(bg1)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   task automatic report();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
         report();
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      b_cyc = 1'b1; b_stb = 1'b1; b_we = 1'b1; b_adr = a; b_wdat = d;
      do @(negedge clk); while (!ack);
      b_cyc = 1'b0; b_stb = 1'b0; b_we = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d, output int waited);
      @(negedge clk);
      b_cyc = 1'b1; b_stb = 1'b1; b_we = 1'b0; b_adr = a;
      waited = 0;
      do begin @(negedge clk); waited++; end while (!ack);
      d = rdat;
      b_cyc = 1'b0; b_stb = 1'b0;
   endtask

   task automatic set_slave(input logic [31:0] w);
      if (sel) sw1 = w; else sw0 = w;
   endtask

   task automatic do_xfer(input logic [31:0] tx, input logic [31:0] sw,
                          output logic [31:0] rx, output logic [31:0] fin);
      logic [31:0] d;
      int c;
      bus_write(A_ARM, 0);
      bus_read(A_WAIT, d, c);
      set_slave(sw);
      bus_write(A_TXD, tx);
      bus_write(A_ARM, 1);
      bus_read(A_WAIT, fin, c);
      bus_read(A_RXD, rx, c);
      bus_write(A_ARM, 0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      int c;
      for (int s = 0; s < 2; s++) begin
         sel = s[0];
         bus_read(A_STATUS, d, c);
         check("R1 status after reset", d, 32'h1);
         bus_read(A_ARM, d, c);
         check("R1 arm after reset", d, 32'h0);
         bus_read(A_TXD, d, c);
         check("R1 tx after reset", d, 32'h0);
         bus_read(A_RXD, d, c);
         check("R1 rx after reset", d, 32'h0);
         check("R1 cs_n idle high", 32'(sel ? cs1 : cs0), 32'h1);
         check("R1 sck idle low", 32'(sel ? sck1 : sck0), 32'h0);
      end
   endtask

   task automatic t_exchange(input logic s);
      logic [31:0] rx, fin, txv, swv, mask;
      sel = s;
      mask = s ? 32'hFFF : 32'hFF;
      for (int k = 0; k < 3; k++) begin
         case (k)
            0: begin txv = 32'hA5C; swv = 32'h3E1; end
            1: begin txv = 32'h801; swv = 32'h180; end
            default: begin txv = 32'hFFF; swv = 32'h000; end
         endcase
         txv = txv & mask;
         swv = swv & mask;
         do_xfer(txv, swv, rx, fin);
         check("R2 finished after transfer", fin, 32'h2);
         check("R4 word seen on MOSI", s ? got1 : got0, txv);
         check("R4 word taken from MISO", rx, swv);
         check("R6 rising edges per word", 32'(s ? lr1 : lr0), s ? W1 : W0);
      end
      check("R5 MOSI changes only on the launch edge", 32'(s ? bp1 : bp0), 32'h0);
      check("R6 R7 half-period and tail timing", 32'(s ? bg1 : bg0), 32'h0);
   endtask

   task automatic t_status();
      logic [31:0] d;
      int c;
      sel = 1'b0;
      bus_write(A_ARM, 0);
      bus_read(A_STATUS, d, c);
      check("R2 ready when idle", d, 32'h1);
      set_slave(32'h5A);
      bus_write(A_TXD, 32'hC3);
      bus_write(A_ARM, 1);
      bus_read(A_STATUS, d, c);
      check("R2 zero while busy", d, 32'h0);
      check("R7 cs_n low mid transfer", 32'(cs0), 32'h0);
      bus_read(A_WAIT, d, c);
      check("R3 blocking read returns finished", d, 32'h2);
      bus_read(A_STATUS, d, c);
      check("R2 finished while armed", d, 32'h2);
      check("R7 cs_n high at finish", 32'(cs0), 32'h1);
      bus_write(A_ARM, 0);
      bus_read(A_STATUS, d, c);
      check("R2 ready after disarm", d, 32'h1);
   endtask

   task automatic t_wait();
      logic [31:0] d;
      int c;
      sel = 1'b0;
      bus_read(A_WAIT, d, c);
      check("R3 idle blocking read value", d, 32'h1);
      check("R3 idle blocking read not stalled", 32'(c), 32'h1);
      bus_write(A_TXD, 32'h3C);
      bus_write(A_ARM, 1);
      bus_read(A_WAIT, d, c);
      check("R3 stalled read value", d, 32'h2);
      check("R3 stall covers the transfer", 32'(c >= 2 * W0 * H0), 32'h1);
      bus_write(A_ARM, 0);
   endtask

   task automatic t_abort();
      logic [31:0] rx, fin, d;
      int c;
      sel = 1'b0;
      do_xfer(32'h5A, 32'hC3, rx, fin);
      check("R8 baseline rx", rx, 32'hC3);
      set_slave(32'h11);
      bus_write(A_TXD, 32'h77);
      bus_write(A_ARM, 1);
      repeat (10) @(negedge clk);
      check("R8 transfer under way", 32'(cs0), 32'h0);
      bus_write(A_ARM, 0);
      repeat (2) @(negedge clk);
      check("R8 cs_n released after abort", 32'(cs0), 32'h1);
      check("R8 sck low after abort", 32'(sck0), 32'h0);
      bus_read(A_STATUS, d, c);
      check("R8 ready after abort", d, 32'h1);
      bus_read(A_RXD, d, c);
      check("R8 rx kept after abort", d, 32'hC3);
      do_xfer(32'h66, 32'h99, rx, fin);
      check("R8 next transfer rx", rx, 32'h99);
      check("R8 next transfer MOSI", got0, 32'h66);
   endtask

   task automatic t_hold();
      logic [31:0] d, r1;
      int c;
      sel = 1'b1;
      bus_write(A_ARM, 0);
      bus_read(A_WAIT, d, c);
      set_slave(32'h9C3);
      bus_write(A_TXD, 32'h123);
      bus_write(A_ARM, 1);
      bus_read(A_WAIT, d, c);
      bus_read(A_RXD, r1, c);
      check("R9 rx after completion", r1, 32'h9C3);
      set_slave(32'h000);
      bus_write(A_TXD, 32'h456);
      bus_read(A_RXD, d, c);
      check("R9 rx unchanged by tx write", d, r1);
      bus_write(A_ARM, 0);
      repeat (3) @(negedge clk);
      bus_read(A_RXD, d, c);
      check("R9 rx unchanged by disarm", d, r1);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      int c;
      sel = 1'b0;
      bus_read(5'h14, d, c);
      check("R10 unmapped 0x14 reads zero", d, 32'h0);
      bus_read(5'h1C, d, c);
      check("R10 unmapped 0x1C reads zero", d, 32'h0);
      bus_write(A_TXD, 32'h1234_56C9);
      bus_read(A_TXD, d, c);
      check("R10 tx readback masked", d, 32'hC9);
      bus_write(A_RXD, 32'hFFFF_FFFF);
      bus_read(A_RXD, d, c);
      check("R10 rx write ignored", d, 32'h99);
      bus_write(A_STATUS, 32'hFFFF_FFFF);
      bus_write(A_WAIT, 32'hFFFF_FFFF);
      repeat (2) @(negedge clk);
      check("R10 status write starts nothing", 32'(cs0), 32'h1);
      bus_read(A_STATUS, d, c);
      check("R10 status unchanged by writes", d, 32'h1);
      bus_write(A_ARM, 1);
      bus_read(A_ARM, d, c);
      check("R10 arm readback", d, 32'h1);
      bus_read(A_WAIT, d, c);
      bus_write(A_ARM, 0);
      bus_read(A_ARM, d, c);
      check("R10 arm cleared readback", d, 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      t_reset();
      t_exchange(1'b0);
      t_exchange(1'b1);
      t_status();
      t_wait();
      t_abort();
      t_hold();
      t_regs();
      sel = 1'b0;
      check("R6 R7 timing over all transfers, phase 0", 32'(bg0), 32'h0);
      check("R5 phase 1 launch edge over all transfers", 32'(bp1), 32'h0);
      report();
      $finish;
   end
endmodule